// File: doc/BRIEF.md
# Receive Destination Address Classifier

This block sits behind the receive MAC and decides, for every incoming frame, whether the frame is kept and which of eight receive channels it is steered to. The decision uses only the 48-bit destination address, one error flag and the block's configuration. The configuration is an address table of 32 entries, a 64-bit group-address hash mask, broadcast and multicast channel selects, a per-channel unicast enable, and a catch-all channel. Frames that nothing else accepts can be sent to the catch-all channel, where they are tagged as not matched.

Software fills the table through a small register port. It writes a row index, then the upper 32 address bits (which are only staged), then a low word. The low word carries the lower 16 address bits and the row's control bits, and writing it commits the whole row. The classifier takes one frame per clock and returns each decision exactly two clocks after the frame was presented.

Top module: `rx_dst_classifier`

## Requirements
- R1: After synchronous reset, `res_valid` is 0, every table row is invalid, all mode bits and unicast enables are 0, and a presented frame is not accepted.
- R2: A frame presented with `frm_valid` high before clock edge N gives `res_valid` high after edge N+1 and not before. Frames may arrive on consecutive cycles, and each gets its own result in order.
- R3: Config register 0 selects the row. Register 1 stages address bits 47:16. Writing register 2 commits the row with address bits 15:0 from data bits 15:0, channel from bits 18:16, the accept/discard flag from bit 19 and the valid flag from bit 20. A row whose valid flag is 0 never matches.
- R4: A valid row whose address equals the destination and whose bit 19 is 1 accepts the frame on the row's channel with `res_nomatch` 0. This happens only if the unicast enable for that channel is set.
- R5: A valid matching row whose bit 19 is 0 discards the frame, even when broadcast or hash rules would have accepted it.
- R6: When several valid rows match, the lowest row index decides.
- R7: The all-ones address that matches no row is accepted on the broadcast channel (mode bits 10:8) when broadcast enable (mode bit 13) is 1, and the hash is not consulted.
- R8: The first address byte on the wire is `frm_dst[7:0]`, and `frm_dst[0]`=1 marks a group address. A non-broadcast group address that matches no row is accepted on the multicast channel (mode bits 2:0) when multicast enable (mode bit 5) is 1 and the mask bit is set. Hash index bit k is the XOR of destination bits k, k+6, k+12, ... up to 47. Mask bits 31:0 are held in register 3 and bits 63:32 in register 4.
- R9: An individual address that matches no row is not accepted by the address rules.
- R10: When promiscuous enable (mode bit 21) is 1, a frame not accepted by R4 to R9 and not rejected by R11 is accepted on the promiscuous channel (mode bits 18:16) with `res_nomatch` 1. Otherwise `res_nomatch` is 0.
- R11: A frame with `frm_err` high is rejected outright when error-copy enable (mode bit 22) is 0. When it is 1, the frame is classified normally and `res_err` is 1 on acceptance.
- R12: Writing register 6 sets each unicast enable whose data bit (7:0) is 1. Writing register 7 clears each enable whose data bit is 1. Other enables are left unchanged.
- R13: A rejected frame gives `res_accept`, `res_chan`, `res_nomatch` and `res_err` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 3 | Config register select (0..7) |
| cfg_wdata | input | 32 | Config write data |
| frm_valid | input | 1 | Destination address valid this cycle |
| frm_dst | input | 48 | Destination address, first byte in bits 7:0 |
| frm_err | input | 1 | Frame carries an error |
| res_valid | output | 1 | Classification result valid |
| res_accept | output | 1 | Frame is kept |
| res_chan | output | 3 | Receive channel of a kept frame |
| res_nomatch | output | 1 | Frame kept only by the promiscuous rule |
| res_err | output | 1 | Kept frame carries an error |

## Verification
The hardest case to reach is a destination that several rules claim at once. For example, a group address can have its hash bit set while it also sits in a discard row. Another example is an address stored in two rows with different channels, where only the lower row's verdict may show. The bench builds these overlaps on purpose. It first computes the hash of a chosen group address and sets only that mask bit, then loads the same address into a discard row. It also loads one address into rows 7 and 9, then invalidates row 7 so that the decision must move to row 9.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int ADDR_W     = 48;
  localparam int CH_W       = 3;
  localparam int ADDR_LO_W  = 16;
  localparam int HASH_IDX_W = 6;
  localparam int HASH_BITS  = 1 << HASH_IDX_W;

  // low-word field positions of a table row
  localparam int ROW_CH_LSB    = 16;
  localparam int ROW_FILT_BIT  = 19;
  localparam int ROW_VALID_BIT = 20;

  // mode register field positions
  localparam int MD_MC_LSB = 0;
  localparam int MD_MC_EN  = 5;
  localparam int MD_BC_LSB = 8;
  localparam int MD_BC_EN  = 13;
  localparam int MD_PR_LSB = 16;
  localparam int MD_PR_EN  = 21;
  localparam int MD_ERRCP  = 22;

  typedef enum logic [2:0] {
    REG_ROWSEL = 3'd0,
    REG_ADRHI  = 3'd1,
    REG_ROWLO  = 3'd2,
    REG_HASHLO = 3'd3,
    REG_HASHHI = 3'd4,
    REG_MODE   = 3'd5,
    REG_UNISET = 3'd6,
    REG_UNICLR = 3'd7
  } cfg_reg_e;

  typedef struct packed {
    logic              valid;
    logic              keep;
    logic [CH_W-1:0]   ch;
    logic [ADDR_W-1:0] addr;
  } row_t;

  typedef struct packed {
    logic            err_copy;
    logic            pr_en;
    logic [CH_W-1:0] pr_ch;
    logic            bc_en;
    logic [CH_W-1:0] bc_ch;
    logic            mc_en;
    logic [CH_W-1:0] mc_ch;
  } mode_t;
endpackage

// File: rtl/rxc_cfg_regs.sv
module rxc_cfg_regs
  import rxc_pkg::*;
#(
  parameter int NUM_ROWS = 32,
  parameter int NUM_CHAN = 8,
  localparam int IDX_W   = $clog2(NUM_ROWS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output row_t                 rows [NUM_ROWS],
  output logic [HASH_BITS-1:0] hash_mask,
  output mode_t                mode,
  output logic [NUM_CHAN-1:0]  uni_en
);
  localparam int HI_W = ADDR_W - ADDR_LO_W;

  logic [IDX_W-1:0] row_sel;
  logic [HI_W-1:0]  adr_hi;
  cfg_reg_e         reg_id;

  assign reg_id = cfg_reg_e'(cfg_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_sel   <= '0;
      adr_hi    <= '0;
      hash_mask <= '0;
      mode      <= '0;
      uni_en    <= '0;
    end else if (cfg_we) begin
      case (reg_id)
        REG_ROWSEL: row_sel <= cfg_wdata[IDX_W-1:0];
        REG_ADRHI:  adr_hi  <= cfg_wdata[HI_W-1:0];
        REG_HASHLO: hash_mask[31:0]  <= cfg_wdata;
        REG_HASHHI: hash_mask[63:32] <= cfg_wdata;
        REG_MODE: begin
          mode.mc_ch    <= cfg_wdata[MD_MC_LSB +: CH_W];
          mode.mc_en    <= cfg_wdata[MD_MC_EN];
          mode.bc_ch    <= cfg_wdata[MD_BC_LSB +: CH_W];
          mode.bc_en    <= cfg_wdata[MD_BC_EN];
          mode.pr_ch    <= cfg_wdata[MD_PR_LSB +: CH_W];
          mode.pr_en    <= cfg_wdata[MD_PR_EN];
          mode.err_copy <= cfg_wdata[MD_ERRCP];
        end
        REG_UNISET: uni_en <= uni_en | cfg_wdata[NUM_CHAN-1:0];
        REG_UNICLR: uni_en <= uni_en & ~cfg_wdata[NUM_CHAN-1:0];
        default: ;
      endcase
    end
  end

  // table rows: committed as a whole when the low word is written
  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        rows[i] <= '0;
      end else if (cfg_we && reg_id == REG_ROWLO && row_sel == IDX_W'(i)) begin
        rows[i].valid <= cfg_wdata[ROW_VALID_BIT];
        rows[i].keep  <= cfg_wdata[ROW_FILT_BIT];
        rows[i].ch    <= cfg_wdata[ROW_CH_LSB +: CH_W];
        rows[i].addr  <= {adr_hi, cfg_wdata[ADDR_LO_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/rxc_hash.sv
module rxc_hash
  import rxc_pkg::*;
(
  input  logic [ADDR_W-1:0]     addr,
  output logic [HASH_IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int k = 0; k < HASH_IDX_W; k++) begin
      for (int j = k; j < ADDR_W; j += HASH_IDX_W) begin
        idx[k] = idx[k] ^ addr[j];
      end
    end
  end
endmodule

// File: rtl/rxc_match.sv
module rxc_match
  import rxc_pkg::*;
#(
  parameter int NUM_ROWS = 32
) (
  input  row_t              rows [NUM_ROWS],
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_ROWS-1:0] hits
);
  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_cmp
    assign hits[i] = rows[i].valid && (rows[i].addr == addr);
  end
endmodule

// File: rtl/rxc_decide.sv
module rxc_decide
  import rxc_pkg::*;
#(
  parameter int NUM_ROWS = 32,
  parameter int NUM_CHAN = 8,
  localparam int IDX_W   = $clog2(NUM_ROWS)
) (
  input  row_t                rows [NUM_ROWS],
  input  logic [NUM_ROWS-1:0] hits,
  input  logic                is_bcast,
  input  logic                is_group,
  input  logic                hash_hit,
  input  logic                err,
  input  mode_t               mode,
  input  logic [NUM_CHAN-1:0] uni_en,
  output logic                accept,
  output logic [CH_W-1:0]     chan,
  output logic                nomatch,
  output logic                err_out
);
  logic [IDX_W-1:0] sel;
  row_t             win;
  logic             prim_acc;
  logic [CH_W-1:0]  prim_ch;

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (hits[i]) sel = IDX_W'(i);
    end
  end

  assign win = rows[sel];

  always_comb begin
    prim_acc = 1'b0;
    prim_ch  = '0;
    if (|hits) begin
      if (win.keep && uni_en[win.ch]) begin
        prim_acc = 1'b1;
        prim_ch  = win.ch;
      end
    end else if (is_bcast) begin
      if (mode.bc_en) begin
        prim_acc = 1'b1;
        prim_ch  = mode.bc_ch;
      end
    end else if (is_group) begin
      if (mode.mc_en && hash_hit) begin
        prim_acc = 1'b1;
        prim_ch  = mode.mc_ch;
      end
    end
  end

  always_comb begin
    accept  = 1'b0;
    chan    = '0;
    nomatch = 1'b0;
    err_out = 1'b0;
    if (err && !mode.err_copy) begin
      accept = 1'b0;
    end else if (prim_acc) begin
      accept  = 1'b1;
      chan    = prim_ch;
      err_out = err;
    end else if (mode.pr_en) begin
      accept  = 1'b1;
      chan    = mode.pr_ch;
      nomatch = 1'b1;
      err_out = err;
    end
  end
endmodule

// File: rtl/rx_dst_classifier.sv
module rx_dst_classifier
  import rxc_pkg::*;
#(
  parameter int NUM_ROWS = 32,
  parameter int NUM_CHAN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              frm_valid,
  input  logic [47:0]       frm_dst,
  input  logic              frm_err,
  output logic              res_valid,
  output logic              res_accept,
  output logic [2:0]        res_chan,
  output logic              res_nomatch,
  output logic              res_err
);
  row_t                 rows [NUM_ROWS];
  logic [HASH_BITS-1:0] hash_mask;
  mode_t                mode_q;
  logic [NUM_CHAN-1:0]  uni_en;

  logic [NUM_ROWS-1:0]   hits;
  logic [HASH_IDX_W-1:0] hidx;

  // stage 1 registers
  logic                s1_valid;
  logic [NUM_ROWS-1:0] s1_hits;
  logic                s1_bcast;
  logic                s1_group;
  logic                s1_hash;
  logic                s1_err;

  logic            d_accept;
  logic [CH_W-1:0] d_chan;
  logic            d_nomatch;
  logic            d_err;

  rxc_cfg_regs #(.NUM_ROWS(NUM_ROWS), .NUM_CHAN(NUM_CHAN)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rows(rows), .hash_mask(hash_mask),
    .mode(mode_q), .uni_en(uni_en)
  );

  rxc_match #(.NUM_ROWS(NUM_ROWS)) u_match (
    .rows(rows), .addr(frm_dst), .hits(hits)
  );

  rxc_hash u_hash (.addr(frm_dst), .idx(hidx));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_hits  <= '0;
      s1_bcast <= 1'b0;
      s1_group <= 1'b0;
      s1_hash  <= 1'b0;
      s1_err   <= 1'b0;
    end else begin
      s1_valid <= frm_valid;
      s1_hits  <= frm_valid ? hits : '0;
      s1_bcast <= frm_valid && (&frm_dst);
      s1_group <= frm_valid && frm_dst[0];
      s1_hash  <= frm_valid && hash_mask[hidx];
      s1_err   <= frm_valid && frm_err;
    end
  end

  rxc_decide #(.NUM_ROWS(NUM_ROWS), .NUM_CHAN(NUM_CHAN)) u_decide (
    .rows(rows), .hits(s1_hits), .is_bcast(s1_bcast), .is_group(s1_group),
    .hash_hit(s1_hash), .err(s1_err), .mode(mode_q), .uni_en(uni_en),
    .accept(d_accept), .chan(d_chan), .nomatch(d_nomatch), .err_out(d_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_accept  <= 1'b0;
      res_chan    <= '0;
      res_nomatch <= 1'b0;
      res_err     <= 1'b0;
    end else begin
      res_valid   <= s1_valid;
      res_accept  <= s1_valid && d_accept;
      res_chan    <= s1_valid ? d_chan : '0;
      res_nomatch <= s1_valid && d_nomatch;
      res_err     <= s1_valid && d_err;
    end
  end
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker (
  input logic       clk,
  input logic       rst,
  input logic       frm_valid,
  input logic       res_valid,
  input logic       res_accept,
  input logic [2:0] res_chan,
  input logic       res_nomatch,
  input logic       res_err,
  input logic       err_copy
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !res_valid);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    frm_valid |-> ##2 res_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |-> ##2 !res_valid);

  // R13
  reject_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_accept) |-> (res_chan == 3'd0 && !res_nomatch && !res_err));

  // R10
  nomatch_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_nomatch) |-> res_accept);

  // R11
  err_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_err) |-> (res_accept && $past(err_copy)));
endmodule

bind rx_dst_classifier rxc_checker u_chk (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .res_valid(res_valid),
  .res_accept(res_accept), .res_chan(res_chan), .res_nomatch(res_nomatch),
  .res_err(res_err), .err_copy(mode_q.err_copy)
);

// File: tb/rx_dst_classifier_test.sv
module rx_dst_classifier_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frm_valid = 1'b0;
  logic [47:0] frm_dst = '0;
  logic        frm_err = 1'b0;
  logic        res_valid, res_accept, res_nomatch, res_err;
  logic [2:0]  res_chan;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [47:0] ADR_A = 48'h6655_4433_2210;
  localparam logic [47:0] ADR_C = 48'h0102_0304_0508;
  localparam logic [47:0] ADR_D = 48'h7777_1111_2222;
  localparam logic [47:0] ADR_G = 48'h00AA_BBCC_DD01;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  always #5 clk = ~clk;

  rx_dst_classifier uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_dst(frm_dst),
    .frm_err(frm_err), .res_valid(res_valid), .res_accept(res_accept),
    .res_chan(res_chan), .res_nomatch(res_nomatch), .res_err(res_err)
  );

  function automatic logic [5:0] hfold(input logic [47:0] a);
    logic [5:0] h = '0;
    for (int k = 0; k < 6; k++)
      for (int j = k; j < 48; j += 6) h[k] = h[k] ^ a[j];
    return h;
  endfunction

  function automatic logic [31:0] mode_w(input logic [2:0] mc, input logic mce,
                                         input logic [2:0] bc, input logic bce,
                                         input logic [2:0] pr, input logic pre,
                                         input logic ec);
    logic [31:0] w = '0;
    w[2:0] = mc; w[5] = mce; w[10:8] = bc; w[13] = bce;
    w[18:16] = pr; w[21] = pre; w[22] = ec;
    return w;
  endfunction

  // packed result: {valid, accept, nomatch, err, chan}
  task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got v/a/nm/e/ch=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {res_valid, res_accept, res_nomatch, res_err, res_chan};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_row(input int idx, input logic [47:0] a, input logic [2:0] ch,
                         input logic keep, input logic vld);
    wr(3'd0, 32'(idx));
    wr(3'd1, a[47:16]);
    wr(3'd2, {11'd0, vld, keep, ch, a[15:0]});
  endtask

  task automatic classify(input string req, input logic [47:0] dst, input logic err,
                          input logic acc, input logic [2:0] ch, input logic nm,
                          input logic er);
    @(negedge clk);
    frm_valid = 1'b1; frm_dst = dst; frm_err = err;
    @(negedge clk);
    frm_valid = 1'b0; frm_err = 1'b0;
    @(negedge clk);
    chk(req, outs(), {1'b1, acc, nm, er, ch});
  endtask

  task automatic t_reset();
    chk("R1 idle in reset", outs(), 7'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 idle after reset", outs(), 7'b0);
    classify("R1 empty config rejects", ADR_A, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
    classify("R13 reject broadcast at reset", BCAST, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_row_match();
    put_row(3, ADR_A, 3'd5, 1'b1, 1'b1);
    wr(3'd6, 32'h20);
    classify("R4 R3 row match", ADR_A, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0);
    classify("R9 individual no hit", ADR_A ^ 48'h100, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_unicast();
    wr(3'd7, 32'h20);
    classify("R12 R4 unicast cleared", ADR_A, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
    wr(3'd6, 32'hFF);
    wr(3'd7, 32'h01);
    classify("R12 other enables kept", ADR_A, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0);
  endtask

  task automatic t_priority();
    put_row(7, ADR_C, 3'd2, 1'b1, 1'b1);
    put_row(9, ADR_C, 3'd6, 1'b1, 1'b1);
    classify("R6 lowest row wins", ADR_C, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0);
    put_row(7, ADR_C, 3'd2, 1'b1, 1'b0);
    classify("R3 invalid row skipped", ADR_C, 1'b0, 1'b1, 3'd6, 1'b0, 1'b0);
  endtask

  task automatic t_bcast();
    wr(3'd5, mode_w(3'd0, 1'b0, 3'd4, 1'b1, 3'd0, 1'b0, 1'b0));
    classify("R7 broadcast accepted", BCAST, 1'b0, 1'b1, 3'd4, 1'b0, 1'b0);
    wr(3'd5, 32'h0);
    classify("R7 broadcast disabled", BCAST, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_mcast();
    logic [5:0] h = hfold(ADR_G);
    if (h >= 6'd32) wr(3'd4, 32'h1 << (h - 6'd32));
    else            wr(3'd3, 32'h1 << h);
    wr(3'd5, mode_w(3'd3, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0));
    classify("R8 hash hit", ADR_G, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0);
    classify("R8 hash miss", ADR_G ^ 48'h2, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
    wr(3'd5, 32'h0);
    classify("R8 multicast disabled", ADR_G, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_filter();
    wr(3'd5, mode_w(3'd3, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0));
    put_row(4, ADR_G, 3'd1, 1'b0, 1'b1);
    classify("R5 discard row beats hash", ADR_G, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_promisc();
    wr(3'd5, mode_w(3'd3, 1'b1, 3'd0, 1'b0, 3'd7, 1'b1, 1'b0));
    classify("R10 discarded to promisc", ADR_G, 1'b0, 1'b1, 3'd7, 1'b1, 1'b0);
    classify("R10 no hit to promisc", ADR_D, 1'b0, 1'b1, 3'd7, 1'b1, 1'b0);
    classify("R10 match keeps row channel", ADR_A, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0);
  endtask

  task automatic t_error();
    classify("R11 error dropped", ADR_A, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0);
    classify("R11 error not promisc", ADR_D, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0);
    wr(3'd5, mode_w(3'd3, 1'b1, 3'd0, 1'b0, 3'd7, 1'b1, 1'b1));
    classify("R11 error copied", ADR_A, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1);
    classify("R11 error copied promisc", ADR_D, 1'b1, 1'b1, 3'd7, 1'b1, 1'b1);
  endtask

  task automatic t_pipeline();
    @(negedge clk);
    frm_valid = 1'b1; frm_dst = ADR_A; frm_err = 1'b0;
    @(negedge clk);
    chk("R2 not yet after one edge", {6'b0, res_valid}, 7'b0);
    frm_dst = ADR_D;
    @(negedge clk);
    frm_valid = 1'b0;
    chk("R2 first of pair", outs(), {4'b1100, 3'd5});
    @(negedge clk);
    chk("R2 second of pair", outs(), {4'b1110, 3'd7});
    @(negedge clk);
    chk("R2 idle after pair", outs(), 7'b0);
  endtask

  initial begin
    t_reset();
    t_row_match();
    t_unicast();
    t_priority();
    t_bcast();
    t_mcast();
    t_filter();
    t_promisc();
    t_error();
    t_pipeline();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule